// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel bytes into framed asynchronous serial characters. A byte written from the register side lands in a one-entry holding buffer. From there it moves into a shift register, which sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, and finally one, one and a half or two high stop bits. The bit rate comes from a transmit tick enable that runs at 1, 16 or 64 times the bit rate. Every serial bit lasts that many ticks.

Two status outputs track the two storage stages. `txReady` shows that the holding buffer can accept a byte. `txEmpty` shows that the shift register has nothing left to send. A new character starts only when transmission is enabled and the clear-to-send input is asserted low. A character that is already on the line always runs to the end. While the buffer holds a byte, the next start bit follows the last stop tick directly, with no idle gap. A break control holds the line low for as long as it is set.

Top module: `async_tx`

## Requirements
- R1: Out of reset, `txd` is 1, `txReady` is 1 and `txEmpty` is 1.
- R2: A character is a low start bit, then the data bits LSB first, then high stop bits, and the line is high while idle. Each bit lasts F `txTick` pulses, where `cfgFactor` 0 gives F=1, 1 gives F=16, and 2 or 3 gives F=64.
- R3: `cfgDataBits` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Byte bits above the selected width are not sent.
- R4: When `cfgParityEn` is 1, one parity bit follows the data bits. With `cfgParityEven`=1 the data bits and the parity bit together hold an even number of ones. With `cfgParityEven`=0 they hold an odd number.
- R5: `cfgStop` 0 gives a stop period of F ticks, 2 or 3 gives 2F ticks, and 1 gives F+F/2 ticks, except at F=1, where 1 gives 2 ticks.
- R6: `txReady` goes low in the cycle after a write is accepted into an empty buffer. It returns high in the cycle after the byte moves into the shift register.
- R7: `txEmpty` goes low in the cycle after a byte moves into the shift register. At that same time the start bit appears on `txd`. `txEmpty` returns high in the cycle after the final stop tick, unless another byte is loaded at that point.
- R8: A write while the holding buffer is full is ignored. The buffered byte is sent unchanged, and the ignored byte is never sent.
- R9: A byte moves from the buffer into the shift register only in a cycle where `txEnable` is 1 and `ctsN` is 0. Otherwise it waits in the buffer and the line stays high.
- R10: Dropping `txEnable` or raising `ctsN` after a character has started does not shorten or alter that character.
- R11: A byte that is buffered when the previous stop period ends starts its start bit on the very next cycle, with no idle bit.
- R12: While `sendBreak` is 1, `txd` is 0 whatever the shifter is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txTick | input | 1 | Transmit clock enable, F pulses per serial bit |
| cfgFactor | input | 2 | Clock factor: 0 = 1x, 1 = 16x, 2/3 = 64x |
| cfgDataBits | input | 2 | Data width: 0..3 = 5..8 bits |
| cfgParityEn | input | 1 | Adds a parity bit when 1 |
| cfgParityEven | input | 1 | 1 = even parity, 0 = odd parity |
| cfgStop | input | 2 | Stop length: 0 = 1, 1 = 1.5, 2/3 = 2 bits |
| txEnable | input | 1 | Allows a new character to start |
| sendBreak | input | 1 | Forces the line low |
| ctsN | input | 1 | Clear to send, active low |
| wrValid | input | 1 | Writes `wrData` into the holding buffer |
| wrData | input | 8 | Byte to send |
| txd | output | 1 | Serial line |
| txReady | output | 1 | Holding buffer is empty |
| txEmpty | output | 1 | Shift register is empty |

## Verification
A write is taken at clock edge T0, so `txReady` is low at the first sample after T0. If start is allowed, the byte moves into the shifter at T1. The bench then expects `txReady` high, `txEmpty` low and `txd` low at the sample after T1. With `txTick` held high, each bit then covers exactly F consecutive samples, and the whole frame covers F*(1+data+parity) plus the stop ticks. The bench records the line once per cycle at the falling clock edge, starting from the first low sample. It reads each bit at its centre sample and checks the frame length from the cycle in which `txEmpty` rises, or from the next start bit when characters run back to back.

// File: rtl/txu_pkg.sv
package txu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PARITY
  } lineSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     load;    // buffer -> shifter transfer
    logic     shift;   // advance to next data bit
    lineSel_t lineSel; // source of the serial line
  } txStrobes_t;

endpackage

// File: rtl/txu_ctrl.sv
module txu_ctrl
  import txu_pkg::*;
#(
  parameter int FACTOR_MID  = 16,
  parameter int FACTOR_HIGH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txTick,
  input  logic [1:0] cfgFactor,
  input  logic [1:0] cfgDataBits,
  input  logic       cfgParityEn,
  input  logic [1:0] cfgStop,
  input  logic       txEnable,
  input  logic       ctsN,
  input  logic       bufFull,
  output txStrobes_t strobes,
  output logic       shifterBusy
);

  localparam int CW = $clog2(2 * FACTOR_HIGH + 1);

  txState_t       state, stateNext;
  logic [CW-1:0]  tickCnt;
  logic [CW-1:0]  bitTicks, stopTicks, limit;
  logic [2:0]     bitIdx, bitIdxNext, dataLast;
  logic           bitDone, startOk;

  always_comb begin
    unique case (cfgFactor)
      2'd0:    bitTicks = CW'(1);
      2'd1:    bitTicks = CW'(FACTOR_MID);
      default: bitTicks = CW'(FACTOR_HIGH);
    endcase
  end

  always_comb begin
    unique case (cfgStop)
      2'd0:    stopTicks = bitTicks;
      2'd1:    stopTicks = (cfgFactor == 2'd0) ? CW'(2) : bitTicks + (bitTicks >> 1);
      default: stopTicks = bitTicks << 1;
    endcase
  end

  assign limit    = (state == ST_STOP) ? stopTicks : bitTicks;
  assign bitDone  = txTick && (tickCnt == limit - CW'(1));
  assign startOk  = bufFull && txEnable && !ctsN;
  assign dataLast = 3'(cfgDataBits) + 3'd4;

  always_comb begin
    stateNext     = state;
    bitIdxNext    = bitIdx;
    strobes.load  = 1'b0;
    strobes.shift = 1'b0;
    unique case (state)
      ST_IDLE: if (startOk) begin
        strobes.load = 1'b1;
        stateNext    = ST_START;
      end
      ST_START: if (bitDone) begin
        stateNext  = ST_DATA;
        bitIdxNext = 3'd0;
      end
      ST_DATA: if (bitDone) begin
        strobes.shift = 1'b1;
        if (bitIdx == dataLast)
          stateNext = cfgParityEn ? ST_PARITY : ST_STOP;
        else
          bitIdxNext = bitIdx + 3'd1;
      end
      ST_PARITY: if (bitDone) stateNext = ST_STOP;
      ST_STOP: if (bitDone) begin
        if (startOk) begin
          strobes.load = 1'b1;
          stateNext    = ST_START;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_START:  strobes.lineSel = LINE_SPACE;
      ST_DATA:   strobes.lineSel = LINE_DATA;
      ST_PARITY: strobes.lineSel = LINE_PARITY;
      default:   strobes.lineSel = LINE_MARK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitIdx  <= '0;
      tickCnt <= '0;
    end else begin
      state  <= stateNext;
      bitIdx <= bitIdxNext;
      if (bitDone || strobes.load || state == ST_IDLE)
        tickCnt <= '0;
      else if (txTick)
        tickCnt <= tickCnt + CW'(1);
    end
  end

  assign shifterBusy = (state != ST_IDLE);

endmodule

// File: rtl/txu_datapath.sv
module txu_datapath
  import txu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        cfgDataBits,
  input  logic              cfgParityEven,
  input  logic              sendBreak,
  input  txStrobes_t        strobes,
  output logic              bufFull,
  output logic              txd
);

  logic [DATA_W-1:0] bufData, shReg, dataMask, maskedBuf;
  logic              parBit, lineBit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign dataMask[i] = (i < 32'(cfgDataBits) + 5);
  end

  assign maskedBuf = bufData & dataMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      bufData <= '0;
    end else if (strobes.load) begin
      bufFull <= 1'b0;
    end else if (wrValid && !bufFull) begin
      bufFull <= 1'b1;
      bufData <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
    end else if (strobes.load) begin
      shReg  <= maskedBuf;
      parBit <= cfgParityEven ? ^maskedBuf : ~^maskedBuf;
    end else if (strobes.shift) begin
      shReg  <= shReg >> 1;
    end
  end

  always_comb begin
    unique case (strobes.lineSel)
      LINE_SPACE:  lineBit = 1'b0;
      LINE_DATA:   lineBit = shReg[0];
      LINE_PARITY: lineBit = parBit;
      default:     lineBit = 1'b1;
    endcase
  end

  assign txd = sendBreak ? 1'b0 : lineBit;

endmodule

// File: rtl/async_tx.sv
module async_tx
  import txu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FACTOR_MID  = 16,
  parameter int FACTOR_HIGH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txTick,
  input  logic [1:0]        cfgFactor,
  input  logic [1:0]        cfgDataBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityEven,
  input  logic [1:0]        cfgStop,
  input  logic              txEnable,
  input  logic              sendBreak,
  input  logic              ctsN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              txd,
  output logic              txReady,
  output logic              txEmpty
);

  txStrobes_t strobes;
  logic       bufFull, shifterBusy;

  txu_ctrl #(.FACTOR_MID(FACTOR_MID), .FACTOR_HIGH(FACTOR_HIGH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txTick      (txTick),
    .cfgFactor   (cfgFactor),
    .cfgDataBits (cfgDataBits),
    .cfgParityEn (cfgParityEn),
    .cfgStop     (cfgStop),
    .txEnable    (txEnable),
    .ctsN        (ctsN),
    .bufFull     (bufFull),
    .strobes     (strobes),
    .shifterBusy (shifterBusy)
  );

  txu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .wrValid       (wrValid),
    .wrData        (wrData),
    .cfgDataBits   (cfgDataBits),
    .cfgParityEven (cfgParityEven),
    .sendBreak     (sendBreak),
    .strobes       (strobes),
    .bufFull       (bufFull),
    .txd           (txd)
  );

  assign txReady = !bufFull;
  assign txEmpty = !shifterBusy;

endmodule

// File: rtl/async_tx_checker.sv
module async_tx_checker (
  input logic clk,
  input logic rstN,
  input logic wrValid,
  input logic txEnable,
  input logic ctsN,
  input logic sendBreak,
  input logic txd,
  input logic txReady,
  input logic txEmpty
);

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && txReady |=> !txReady);                              // R6

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> $past(txEnable) && !$past(ctsN));           // R9

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) && !sendBreak |-> !txd);                        // R7

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty && !sendBreak |-> txd);                                // R2

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !txd);                                           // R12

  AST_READY_VIA_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> !txEmpty);                                  // R6

endmodule

bind async_tx async_tx_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrValid   (wrValid),
  .txEnable  (txEnable),
  .ctsN      (ctsN),
  .sendBreak (sendBreak),
  .txd       (txd),
  .txReady   (txReady),
  .txEmpty   (txEmpty)
);

// File: tb/async_tx_test.sv
module async_tx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txTick = 1'b1;
  logic [1:0] cfgFactor = 2'd1;
  logic [1:0] cfgDataBits = 2'd3;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityEven = 1'b0;
  logic [1:0] cfgStop = 2'd0;
  logic       txEnable = 1'b1;
  logic       sendBreak = 1'b0;
  logic       ctsN = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       txd, txReady, txEmpty;

  int checkCnt = 0;
  int failCnt  = 0;

  int F, nData, stopT, frameLen;
  logic lineLog [0:1023];

  always #4 clk = ~clk;

  async_tx uut (
    .clk(clk), .rstN(rstN), .txTick(txTick), .cfgFactor(cfgFactor),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityEven(cfgParityEven), .cfgStop(cfgStop), .txEnable(txEnable),
    .sendBreak(sendBreak), .ctsN(ctsN), .wrValid(wrValid), .wrData(wrData),
    .txd(txd), .txReady(txReady), .txEmpty(txEmpty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected frame geometry from R2, R3, R5
  task automatic setMode(input logic [1:0] fc, input logic [1:0] db,
                         input logic pe, input logic pev, input logic [1:0] sc);
    @(negedge clk);
    cfgFactor = fc; cfgDataBits = db; cfgParityEn = pe;
    cfgParityEven = pev; cfgStop = sc;
    F = (fc == 0) ? 1 : (fc == 1) ? 16 : 64;
    nData = 5 + db;
    if (sc == 0) stopT = F;
    else if (sc == 1) stopT = (F == 1) ? 2 : F + F / 2;
    else stopT = 2 * F;
    frameLen = F * (1 + nData + (pe ? 1 : 0)) + stopT;
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk);
    wrValid = 1'b1; wrData = b;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // Records one frame starting at the first low sample; leaves the bench at
  // the sample just after the frame.
  task automatic recordFrame(input string req);
    int guard = 0;
    while (txd !== 1'b0 && guard < 2000) begin
      @(negedge clk); guard++;
    end
    chk({req, " start seen"}, int'(guard < 2000), 1);
    for (int i = 0; i < frameLen; i++) begin
      lineLog[i] = txd;
      if (i == frameLen - 1) chk({req, " busy through last stop tick"}, int'(txEmpty), 0);
      @(negedge clk);
    end
  endtask

  task automatic decodeFrame(input string req, input logic [7:0] b);
    logic [7:0] got = '0;
    logic [7:0] masked;
    int stopOk = 1;
    masked = b & 8'((1 << nData) - 1);
    chk({req, " start bit"}, int'(lineLog[F / 2]), 0);
    for (int k = 0; k < nData; k++) got[k] = lineLog[F * (1 + k) + F / 2];
    chk({req, " data LSB first"}, int'(got), int'(masked));
    if (cfgParityEn) begin
      logic pexp;
      pexp = cfgParityEven ? ($countones(masked) % 2 == 1) : ($countones(masked) % 2 == 0);
      chk({req, " R4 parity bit"}, int'(lineLog[F * (1 + nData) + F / 2]), int'(pexp));
    end
    for (int i = F * (1 + nData + (cfgParityEn ? 1 : 0)); i < frameLen; i++)
      if (lineLog[i] !== 1'b1) stopOk = 0;
    chk({req, " R5 stop high for full length"}, stopOk, 1);
  endtask

  task automatic singleFrame(input string req, input logic [7:0] b);
    writeByte(b);
    recordFrame(req);
    decodeFrame(req, b);
    chk({req, " R7 empty after stop"}, int'(txEmpty), 1);
    chk({req, " R2 idle mark"}, int'(txd), 1);
  endtask

  task automatic testReset();
    chk("R1 txd", int'(txd), 1);
    chk("R1 txReady", int'(txReady), 1);
    chk("R1 txEmpty", int'(txEmpty), 1);
  endtask

  task automatic testHandoffTiming();
    setMode(2'd1, 2'd3, 1'b0, 1'b0, 2'd0);
    writeByte(8'hA5);
    chk("R6 ready low after write", int'(txReady), 0);
    chk("R7 still empty before move", int'(txEmpty), 1);
    @(negedge clk);
    chk("R6 ready high after move", int'(txReady), 1);
    chk("R7 empty low after move", int'(txEmpty), 0);
    chk("R7 start bit with move", int'(txd), 0);
    recordFrame("R2 8N1 16x");
    decodeFrame("R2 8N1 16x", 8'hA5);
    chk("R7 empty after stop", int'(txEmpty), 1);
  endtask

  task automatic testGating();
    setMode(2'd1, 2'd3, 1'b0, 1'b0, 2'd0);
    ctsN = 1'b1;
    writeByte(8'h5A);
    repeat (40) @(negedge clk);
    chk("R9 cts high holds line", int'(txd), 1);
    chk("R9 cts high keeps empty", int'(txEmpty), 1);
    chk("R9 cts high keeps buffer", int'(txReady), 0);
    txEnable = 1'b0; ctsN = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 disable holds line", int'(txd), 1);
    chk("R9 disable keeps empty", int'(txEmpty), 1);
    txEnable = 1'b1;
    recordFrame("R9 release");
    decodeFrame("R9 release", 8'h5A);
  endtask

  task automatic testMidFrameDrop();
    setMode(2'd1, 2'd3, 1'b1, 1'b1, 2'd0);
    writeByte(8'h96);
    fork
      recordFrame("R10 drop");
      begin repeat (40) @(negedge clk); ctsN = 1'b1; txEnable = 1'b0; end
    join
    decodeFrame("R10 drop", 8'h96);
    chk("R10 empty after completed frame", int'(txEmpty), 1);
    ctsN = 1'b0; txEnable = 1'b1;
  endtask

  task automatic testBackToBack();
    setMode(2'd1, 2'd2, 1'b0, 1'b0, 2'd0);
    writeByte(8'h41);
    fork
      recordFrame("R11 first");
      begin @(negedge clk); writeByte(8'h2E); end
    join
    decodeFrame("R11 first", 8'h41);
    chk("R11 next start immediate", int'(txd), 0);
    chk("R11 shifter stays busy", int'(txEmpty), 0);
    recordFrame("R11 second");
    decodeFrame("R11 second", 8'h2E);
    chk("R11 empty after second", int'(txEmpty), 1);
  endtask

  task automatic testOverflow();
    setMode(2'd1, 2'd3, 1'b0, 1'b0, 2'd0);
    ctsN = 1'b1;
    writeByte(8'h3C);
    writeByte(8'hC3);
    chk("R8 buffer still full", int'(txReady), 0);
    ctsN = 1'b0;
    recordFrame("R8 kept byte");
    decodeFrame("R8 kept byte", 8'h3C);
    chk("R8 buffer drained", int'(txReady), 1);
    repeat (30) @(negedge clk);
    chk("R8 no second frame", int'(txd), 1);
    chk("R8 shifter idle", int'(txEmpty), 1);
  endtask

  task automatic testBreak();
    @(negedge clk);
    sendBreak = 1'b1;
    @(negedge clk);
    chk("R12 break low idle", int'(txd), 0);
    repeat (10) @(negedge clk);
    chk("R12 break held low", int'(txd), 0);
    sendBreak = 1'b0;
    @(negedge clk);
    chk("R12 release to mark", int'(txd), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testHandoffTiming();
    setMode(2'd0, 2'd2, 1'b1, 1'b1, 2'd2);
    singleFrame("R3 R4 7E2 1x", 8'hD3);
    setMode(2'd1, 2'd0, 1'b1, 1'b0, 2'd1);
    singleFrame("R3 R5 5O1.5 16x", 8'hF6);
    setMode(2'd0, 2'd3, 1'b0, 1'b0, 2'd1);
    singleFrame("R5 1.5 at 1x", 8'h81);
    setMode(2'd2, 2'd1, 1'b1, 1'b0, 2'd0);
    singleFrame("R2 R3 6O1 64x", 8'h2B);
    testGating();
    testMidFrameDrop();
    testBackToBack();
    testOverflow();
    testBreak();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule